// File: doc/BRIEF.md
# Stereo/Mono Channel Converter

This block sits between a two-channel audio sample stream and an interface port and reshapes the channel layout on the way through. Two separate lanes are provided, one for the playback direction and one for the capture direction, and each lane has its own static settings. Samples enter and leave through a valid/ready handshake. Each sample carries a one-bit channel tag, 0 for the first channel of a frame and 1 for the second.

A lane works in one of three operations. In pass mode every sample goes through with its own tag. In reduce mode each stereo pair becomes one mono sample, which is channel 0, channel 1 or the arithmetic mean of both. In expand mode each mono sample becomes a pair, and the second channel is either zero or a copy. Input samples are 8, 16 or 32 bits wide and are sign-extended to the full output width before any arithmetic.

Each lane runs a four-state machine. In `ST_FIRST` the lane waits for the start of a frame and samples the live settings. In `ST_SECOND` it waits for the channel-1 sample of a pair. `ST_DUP` presents the channel-0 half of an expanded sample. `ST_TAIL` presents the channel-1 half. The transitions are:
- FIRST→SECOND on a channel-0 sample in pass or reduce mode.
- FIRST→DUP on any sample in expand mode.
- SECOND→FIRST on a channel-1 sample.
- DUP→TAIL when the channel-0 half is taken.
- TAIL→FIRST when the channel-1 half is taken.

All other cases hold the current state.

Top module: `chconv_top`

## Requirements
- R1: In the first cycle after reset is released, both lanes present out_valid low and in_ready high.
- R2: The width code selects the sign-extension: 0 takes bits [7:0], 1 takes bits [15:0], and 2 or 3 take all 32 bits. In pass mode (mode code 0 or 3), each sample leaves sign-extended and keeps its own channel tag.
- R3: Reduce mode (mode code 1) with pick code 0 emits one sample per pair. The sample is the channel-0 value and carries tag 0, and it is emitted only after the channel-1 sample has been accepted.
- R4: Reduce mode with pick code 1 emits the channel-1 value of each pair, with tag 0.
- R5: Reduce mode with pick code 2 or 3 emits the floor of the signed mean of the pair. The mean is computed one bit wider, so that large values of the same sign cannot overflow.
- R6: Expand mode (mode code 2) emits two samples for each input: the sample with tag 0, then a sample with tag 1. When the fill bit is 0 the second sample is zero; when the fill bit is 1 it is a copy of the first.
- R7: In expand mode, in_ready stays low from the cycle after an input is accepted until the cycle after its second output is accepted.
- R8: Mode, pick and fill settings are sampled only at a frame start. A settings change while a pair is half received does not affect that pair.
- R9: The playback and capture lanes act independently under different settings at the same time.
- R10: While out_valid is high and out_ready is low, out_valid, the output data and the output tag hold their values.
- R11: In reduce mode, a channel-1 sample arriving at a frame start is discarded. A second channel-0 sample before the channel-1 sample replaces the held one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pb_mode | input | 2 | Playback operation: 0/3 pass, 1 reduce, 2 expand |
| pb_pick | input | 2 | Playback reduction: 0 ch0, 1 ch1, 2/3 mean |
| pb_fill | input | 1 | Playback expansion fill: 0 zero, 1 copy |
| pb_width | input | 2 | Playback input width: 0 8-bit, 1 16-bit, 2/3 32-bit |
| pb_in_valid | input | 1 | Playback input sample valid |
| pb_in_ready | output | 1 | Playback input sample accepted when high with valid |
| pb_in_data | input | 32 | Playback input sample, right-aligned |
| pb_in_chan | input | 1 | Playback input channel tag |
| pb_out_valid | output | 1 | Playback output valid |
| pb_out_ready | input | 1 | Playback output consumer ready |
| pb_out_data | output | 32 | Playback output sample |
| pb_out_chan | output | 1 | Playback output channel tag |
| cp_mode | input | 2 | Capture operation, same coding as pb_mode |
| cp_pick | input | 2 | Capture reduction, same coding as pb_pick |
| cp_fill | input | 1 | Capture expansion fill |
| cp_width | input | 2 | Capture input width |
| cp_in_valid | input | 1 | Capture input sample valid |
| cp_in_ready | output | 1 | Capture input ready |
| cp_in_data | input | 32 | Capture input sample |
| cp_in_chan | input | 1 | Capture input channel tag |
| cp_out_valid | output | 1 | Capture output valid |
| cp_out_ready | input | 1 | Capture output consumer ready |
| cp_out_data | output | 32 | Capture output sample |
| cp_out_chan | output | 1 | Capture output channel tag |

## Verification
The hardest condition to reach from the ports is a settings change that lands while a pair is half received. Reaching it means stopping the input stream right after a channel-0 sample and then changing the settings before its partner arrives. The bench does this by feeding a single channel-0 sample and waiting until it has been accepted. It then switches the lane from mean reduction to expand, and only afterwards supplies the channel-1 sample. The result must still be the mean, and the next sample must be expanded. Output backpressure runs on an irregular pattern throughout, so that both the expand stall and the output hold occur with out_ready low in many different cycles.

// File: rtl/chconv_pkg.sv
package chconv_pkg;

    typedef enum logic [1:0] {
        OP_PASS     = 2'd0,
        OP_REDUCE   = 2'd1,
        OP_EXPAND   = 2'd2,
        OP_PASS_ALT = 2'd3
    } conv_op_e;

    typedef enum logic [1:0] {
        PICK_CH0      = 2'd0,
        PICK_CH1      = 2'd1,
        PICK_MEAN     = 2'd2,
        PICK_MEAN_ALT = 2'd3
    } pick_e;

    typedef enum logic [1:0] {
        ST_FIRST  = 2'd0,
        ST_SECOND = 2'd1,
        ST_DUP    = 2'd2,
        ST_TAIL   = 2'd3
    } lane_st_e;

    localparam int NARROW_A_W = 8;
    localparam int NARROW_B_W = 16;

endpackage

// File: rtl/chconv_sext.sv
module chconv_sext
    import chconv_pkg::*;
#(
    parameter int SAMPLE_W = 32
) (
    input  logic [1:0]          width_code,
    input  logic [SAMPLE_W-1:0] raw,
    output logic [SAMPLE_W-1:0] ext
);
    localparam int PAD_A = SAMPLE_W - NARROW_A_W;
    localparam int PAD_B = SAMPLE_W - NARROW_B_W;

    always_comb begin
        unique case (width_code)
            2'd0:    ext = {{PAD_A{raw[NARROW_A_W-1]}}, raw[NARROW_A_W-1:0]};
            2'd1:    ext = {{PAD_B{raw[NARROW_B_W-1]}}, raw[NARROW_B_W-1:0]};
            default: ext = raw;
        endcase
    end
endmodule

// File: rtl/chconv_mix.sv
module chconv_mix
    import chconv_pkg::*;
#(
    parameter int SAMPLE_W = 32
) (
    input  pick_e               sel,
    input  logic [SAMPLE_W-1:0] first,
    input  logic [SAMPLE_W-1:0] second,
    output logic [SAMPLE_W-1:0] result
);
    localparam int SUM_W = SAMPLE_W + 1;

    logic [SUM_W-1:0] sum;

    // one guard bit keeps the sum exact; dropping the LSB is an arithmetic shift
    assign sum = {first[SAMPLE_W-1], first} + {second[SAMPLE_W-1], second};

    always_comb begin
        unique case (sel)
            PICK_CH0:                result = first;
            PICK_CH1:                result = second;
            PICK_MEAN, PICK_MEAN_ALT: result = sum[SUM_W-1:1];
        endcase
    end
endmodule

// File: rtl/chconv_lane.sv
module chconv_lane
    import chconv_pkg::*;
#(
    parameter int SAMPLE_W = 32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [1:0]          cfg_op,
    input  logic [1:0]          cfg_pick,
    input  logic                cfg_fill,
    input  logic [1:0]          cfg_width,
    input  logic                in_valid,
    output logic                in_ready,
    input  logic [SAMPLE_W-1:0] in_data,
    input  logic                in_chan,
    output logic                out_valid,
    input  logic                out_ready,
    output logic [SAMPLE_W-1:0] out_data,
    output logic                out_chan
);
    lane_st_e            st_q, st_d;
    conv_op_e            op_q, op_eff;
    pick_e               pick_q, pick_eff;
    logic                fill_q, fill_eff;
    logic [SAMPLE_W-1:0] hold_q;
    logic [SAMPLE_W-1:0] in_ext;
    logic [SAMPLE_W-1:0] mix_res;
    logic                ovalid_q;
    logic [SAMPLE_W-1:0] odata_q;
    logic                ochan_q;
    logic                out_free;
    logic                accept;

    chconv_sext #(.SAMPLE_W(SAMPLE_W)) u_sext (
        .width_code (cfg_width),
        .raw        (in_data),
        .ext        (in_ext)
    );

    chconv_mix #(.SAMPLE_W(SAMPLE_W)) u_mix (
        .sel    (pick_eff),
        .first  (hold_q),
        .second (in_ext),
        .result (mix_res)
    );

    // settings are live only at a frame start, latched copies otherwise
    assign op_eff   = (st_q == ST_FIRST) ? conv_op_e'(cfg_op) : op_q;
    assign pick_eff = (st_q == ST_FIRST) ? pick_e'(cfg_pick)  : pick_q;
    assign fill_eff = (st_q == ST_FIRST) ? cfg_fill           : fill_q;

    assign out_free = !ovalid_q || out_ready;
    assign accept   = in_valid && in_ready;

    // next-state logic
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_FIRST: begin
                if (accept) begin
                    if (op_eff == OP_EXPAND)
                        st_d = ST_DUP;
                    else if (!in_chan)
                        st_d = ST_SECOND;
                end
            end
            ST_SECOND: begin
                if (accept && in_chan)
                    st_d = ST_FIRST;
            end
            ST_DUP: begin
                if (out_ready)
                    st_d = ST_TAIL;
            end
            ST_TAIL: begin
                if (out_ready)
                    st_d = ST_FIRST;
            end
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n)
            st_q <= ST_FIRST;
        else
            st_q <= st_d;
    end

    // outputs and datapath
    always_comb begin
        in_ready  = ((st_q == ST_FIRST) || (st_q == ST_SECOND)) && out_free;
        out_valid = ovalid_q;
        out_data  = odata_q;
        out_chan  = ochan_q;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            op_q     <= OP_PASS;
            pick_q   <= PICK_CH0;
            fill_q   <= 1'b0;
            hold_q   <= '0;
            ovalid_q <= 1'b0;
            odata_q  <= '0;
            ochan_q  <= 1'b0;
        end else begin
            if (st_q == ST_FIRST) begin
                op_q   <= conv_op_e'(cfg_op);
                pick_q <= pick_e'(cfg_pick);
                fill_q <= cfg_fill;
            end
            if (ovalid_q && out_ready)
                ovalid_q <= 1'b0;
            unique case (st_q)
                ST_FIRST, ST_SECOND: begin
                    if (accept) begin
                        case (op_eff)
                            OP_REDUCE: begin
                                if (!in_chan) begin
                                    hold_q <= in_ext;
                                end else if (st_q == ST_SECOND) begin
                                    ovalid_q <= 1'b1;
                                    odata_q  <= mix_res;
                                    ochan_q  <= 1'b0;
                                end
                            end
                            OP_EXPAND: begin
                                ovalid_q <= 1'b1;
                                odata_q  <= in_ext;
                                ochan_q  <= 1'b0;
                                hold_q   <= fill_eff ? in_ext : '0;
                            end
                            default: begin
                                ovalid_q <= 1'b1;
                                odata_q  <= in_ext;
                                ochan_q  <= in_chan;
                            end
                        endcase
                    end
                end
                ST_DUP: begin
                    if (out_ready) begin
                        ovalid_q <= 1'b1;
                        odata_q  <= hold_q;
                        ochan_q  <= 1'b1;
                    end
                end
                ST_TAIL: begin
                end
            endcase
        end
    end

    // R1: idle after reset
    p_reset_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rst_n) |-> (!out_valid && in_ready));

    // R10: output held under backpressure
    p_out_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_chan)));

    // R7: expansion blocks the input
    p_expand_stall_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && op_eff == OP_EXPAND) |=> !in_ready);

    // R6: second half follows the first with tag 1
    p_expand_order_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_DUP && out_ready) |=> (out_valid && out_chan));

    // R3: a completed pair yields a tag-0 result
    p_pair_out_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && st_q == ST_SECOND && op_q == OP_REDUCE && in_chan) |=> (out_valid && !out_chan));

endmodule

// File: rtl/chconv_top.sv
module chconv_top
    import chconv_pkg::*;
#(
    parameter int SAMPLE_W = 32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [1:0]          pb_mode,
    input  logic [1:0]          pb_pick,
    input  logic                pb_fill,
    input  logic [1:0]          pb_width,
    input  logic                pb_in_valid,
    output logic                pb_in_ready,
    input  logic [SAMPLE_W-1:0] pb_in_data,
    input  logic                pb_in_chan,
    output logic                pb_out_valid,
    input  logic                pb_out_ready,
    output logic [SAMPLE_W-1:0] pb_out_data,
    output logic                pb_out_chan,
    input  logic [1:0]          cp_mode,
    input  logic [1:0]          cp_pick,
    input  logic                cp_fill,
    input  logic [1:0]          cp_width,
    input  logic                cp_in_valid,
    output logic                cp_in_ready,
    input  logic [SAMPLE_W-1:0] cp_in_data,
    input  logic                cp_in_chan,
    output logic                cp_out_valid,
    input  logic                cp_out_ready,
    output logic [SAMPLE_W-1:0] cp_out_data,
    output logic                cp_out_chan
);
    localparam int N_DIR = 2;

    logic [N_DIR-1:0][1:0]          mode_a, pick_a, width_a;
    logic [N_DIR-1:0]               fill_a, ivld_a, irdy_a, ichan_a;
    logic [N_DIR-1:0]               ovld_a, ordy_a, ochan_a;
    logic [N_DIR-1:0][SAMPLE_W-1:0] idata_a, odata_a;

    assign mode_a  = {cp_mode, pb_mode};
    assign pick_a  = {cp_pick, pb_pick};
    assign width_a = {cp_width, pb_width};
    assign fill_a  = {cp_fill, pb_fill};
    assign ivld_a  = {cp_in_valid, pb_in_valid};
    assign ichan_a = {cp_in_chan, pb_in_chan};
    assign idata_a = {cp_in_data, pb_in_data};
    assign ordy_a  = {cp_out_ready, pb_out_ready};

    assign pb_in_ready  = irdy_a[0];
    assign pb_out_valid = ovld_a[0];
    assign pb_out_data  = odata_a[0];
    assign pb_out_chan  = ochan_a[0];
    assign cp_in_ready  = irdy_a[1];
    assign cp_out_valid = ovld_a[1];
    assign cp_out_data  = odata_a[1];
    assign cp_out_chan  = ochan_a[1];

    for (genvar d = 0; d < N_DIR; d++) begin : g_lane
        chconv_lane #(.SAMPLE_W(SAMPLE_W)) u_lane (
            .clk       (clk),
            .rst_n     (rst_n),
            .cfg_op    (mode_a[d]),
            .cfg_pick  (pick_a[d]),
            .cfg_fill  (fill_a[d]),
            .cfg_width (width_a[d]),
            .in_valid  (ivld_a[d]),
            .in_ready  (irdy_a[d]),
            .in_data   (idata_a[d]),
            .in_chan   (ichan_a[d]),
            .out_valid (ovld_a[d]),
            .out_ready (ordy_a[d]),
            .out_data  (odata_a[d]),
            .out_chan  (ochan_a[d])
        );
    end
endmodule

// File: tb/sim_chconv_top.sv
module sim_chconv_top;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2.5 clk = ~clk;

    logic [1:0]  mode [2], pick [2], width [2];
    logic        fill [2];
    logic [1:0]  nmode [2], npick [2], nwidth [2];
    logic        nfill [2];
    logic        ivld [2], ird [2], ichan [2];
    logic [31:0] idata [2];
    logic        ovld [2], ordy [2], ochan [2];
    logic [31:0] odata [2];

    chconv_top u0 (
        .clk(clk), .rst_n(rst_n),
        .pb_mode(mode[0]), .pb_pick(pick[0]), .pb_fill(fill[0]), .pb_width(width[0]),
        .pb_in_valid(ivld[0]), .pb_in_ready(ird[0]), .pb_in_data(idata[0]), .pb_in_chan(ichan[0]),
        .pb_out_valid(ovld[0]), .pb_out_ready(ordy[0]), .pb_out_data(odata[0]), .pb_out_chan(ochan[0]),
        .cp_mode(mode[1]), .cp_pick(pick[1]), .cp_fill(fill[1]), .cp_width(width[1]),
        .cp_in_valid(ivld[1]), .cp_in_ready(ird[1]), .cp_in_data(idata[1]), .cp_in_chan(ichan[1]),
        .cp_out_valid(ovld[1]), .cp_out_ready(ordy[1]), .cp_out_data(odata[1]), .cp_out_chan(ochan[1])
    );

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;

    logic [32:0] inq  [2][$];
    logic [32:0] expq [2][$];
    int          mst [2];
    logic [1:0]  lmode [2], lpick [2];
    logic        lfill [2];
    logic [31:0] mhold [2];
    int          pend [2];
    logic        stalled [2];
    logic [32:0] stall_val [2];

    task automatic chk(input bit ok, input string req, input logic [32:0] act, input logic [32:0] expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h (cycle %0d)", req, act, expv, cyc);
        end
    endtask

    function automatic logic [31:0] sx(input logic [1:0] w, input logic [31:0] d);
        if (w == 2'd0) return {{24{d[7]}}, d[7:0]};
        if (w == 2'd1) return {{16{d[15]}}, d[15:0]};
        return d;
    endfunction

    function automatic logic [31:0] mean2(input logic [31:0] a, input logic [31:0] b);
        longint s;
        s = longint'($signed(a)) + longint'($signed(b));
        s = s >>> 1;
        return s[31:0];
    endfunction

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    // behavioural reference for one accepted input
    task automatic model_accept(input int d, input logic [31:0] raw, input logic tag);
        logic [31:0] x;
        logic [31:0] r;
        x = sx(width[d], raw);
        if (mst[d] == 0) begin
            lmode[d] = mode[d];
            lpick[d] = pick[d];
            lfill[d] = fill[d];
        end
        if (lmode[d] == 2'd1) begin
            if (mst[d] == 0) begin
                if (!tag) begin mhold[d] = x; mst[d] = 1; end
            end else if (!tag) begin
                mhold[d] = x;
            end else begin
                if (lpick[d] == 2'd0)      r = mhold[d];
                else if (lpick[d] == 2'd1) r = x;
                else                       r = mean2(mhold[d], x);
                expq[d].push_back({1'b0, r});
                mst[d] = 0;
            end
        end else if (lmode[d] == 2'd2) begin
            expq[d].push_back({1'b0, x});
            expq[d].push_back({1'b1, lfill[d] ? x : 32'd0});
            pend[d] = 2;
        end else begin
            expq[d].push_back({tag, x});
            mst[d] = tag ? 0 : 1;
        end
    endtask

    task automatic step();
        @(negedge clk);
        cyc++;
        if (cyc > 150000) begin
            chk(1'b0, "watchdog", 33'd0, 33'd1);
            finish_run();
        end
        for (int d = 0; d < 2; d++) begin
            mode[d] = nmode[d]; pick[d] = npick[d]; fill[d] = nfill[d]; width[d] = nwidth[d];
            ivld[d] = (inq[d].size() > 0) && (((cyc + d) % 5) != 3);
            if (inq[d].size() > 0) begin
                idata[d] = inq[d][0][31:0];
                ichan[d] = inq[d][0][32];
            end
            ordy[d] = ((cyc * 3 + d) % 7) > 1;
        end
        #1;
        for (int d = 0; d < 2; d++) begin
            // R10: held output must not move
            if (stalled[d])
                chk(ovld[d] && ({ochan[d], odata[d]} == stall_val[d]), "R10 hold",
                    {ochan[d], odata[d]}, stall_val[d]);
            stalled[d] = ovld[d] && !ordy[d];
            stall_val[d] = {ochan[d], odata[d]};
            // R7: no input while an expansion is outstanding
            if (pend[d] > 0)
                chk(!ird[d], "R7 stall", {32'd0, ird[d]}, 33'd0);
            if (ivld[d] && ird[d]) begin
                model_accept(d, idata[d], ichan[d]);
                void'(inq[d].pop_front());
            end
            if (ovld[d] && ordy[d]) begin
                if (expq[d].size() == 0) begin
                    chk(1'b0, "R2-R11 unexpected output", {ochan[d], odata[d]}, 33'd0);
                end else begin
                    chk({ochan[d], odata[d]} == expq[d][0], $sformatf("R2-R9 data lane %0d", d),
                        {ochan[d], odata[d]}, expq[d][0]);
                    void'(expq[d].pop_front());
                end
                if (pend[d] > 0) pend[d]--;
            end
        end
    endtask

    task automatic drain();
        int n = 0;
        while ((inq[0].size() + inq[1].size() + expq[0].size() + expq[1].size()) > 0 && n < 3000) begin
            step();
            n++;
        end
        if (n >= 3000) chk(1'b0, "drain watchdog", 33'd0, 33'd1);
        repeat (3) step();
    endtask

    task automatic setcfg(input int d, input logic [1:0] m, input logic [1:0] p,
                          input logic f, input logic [1:0] w);
        nmode[d] = m; npick[d] = p; nfill[d] = f; nwidth[d] = w;
    endtask

    task automatic put(input int d, input logic tag, input logic [31:0] v);
        inq[d].push_back({tag, v});
    endtask

    initial begin
        for (int d = 0; d < 2; d++) begin
            setcfg(d, 2'd0, 2'd0, 1'b0, 2'd2);
            mode[d] = 2'd0; pick[d] = 2'd0; fill[d] = 1'b0; width[d] = 2'd2;
            ivld[d] = 1'b0; ichan[d] = 1'b0; idata[d] = '0; ordy[d] = 1'b0;
            mst[d] = 0; pend[d] = 0; stalled[d] = 1'b0; mhold[d] = '0;
            lmode[d] = '0; lpick[d] = '0; lfill[d] = 1'b0; stall_val[d] = '0;
        end
        repeat (4) @(posedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        for (int d = 0; d < 2; d++)
            chk(!ovld[d] && ird[d], "R1 reset", {31'd0, ovld[d], ird[d]}, 33'd1);

        // R2 and R9: pass with different widths per lane
        setcfg(0, 2'd0, 2'd0, 1'b0, 2'd0);
        setcfg(1, 2'd3, 2'd0, 1'b0, 2'd1);
        put(0, 1'b0, 32'h0000_00F0); put(0, 1'b1, 32'hABCD_127F);
        put(1, 1'b0, 32'h1234_8001); put(1, 1'b1, 32'h0001_7FFF);
        drain();
        setcfg(0, 2'd0, 2'd0, 1'b0, 2'd2);
        put(0, 1'b0, 32'h8000_0000); put(0, 1'b1, 32'h0000_0001);
        put(0, 1'b1, 32'h0000_0002);
        drain();

        // R3, R4, R9: keep ch0 on playback, keep ch1 on capture
        setcfg(0, 2'd1, 2'd0, 1'b0, 2'd2);
        setcfg(1, 2'd1, 2'd1, 1'b0, 2'd2);
        for (int i = 0; i < 4; i++) begin
            put(0, 1'b0, 32'h100 + i); put(0, 1'b1, 32'h200 + i);
            put(1, 1'b0, 32'h300 + i); put(1, 1'b1, 32'h400 + i);
        end
        drain();

        // R5: mean, including overflow-prone and negative cases
        setcfg(0, 2'd1, 2'd2, 1'b0, 2'd2);
        setcfg(1, 2'd1, 2'd3, 1'b0, 2'd0);
        put(0, 1'b0, 32'h7FFF_FFFF); put(0, 1'b1, 32'h7FFF_FFFF);
        put(0, 1'b0, 32'h8000_0000); put(0, 1'b1, 32'h8000_0000);
        put(0, 1'b0, 32'hFFFF_FFFF); put(0, 1'b1, 32'h0000_0000);
        put(0, 1'b0, 32'h0000_0003); put(0, 1'b1, 32'hFFFF_FFFA);
        put(1, 1'b0, 32'h0000_0080); put(1, 1'b1, 32'h0000_007F);
        put(1, 1'b0, 32'h0000_0080); put(1, 1'b1, 32'h0000_0080);
        drain();

        // R11: stray ch1 dropped, repeated ch0 replaces held sample
        setcfg(0, 2'd1, 2'd0, 1'b0, 2'd2);
        put(0, 1'b1, 32'h55); put(0, 1'b0, 32'h10); put(0, 1'b0, 32'h20); put(0, 1'b1, 32'h30);
        drain();

        // R6, R7: expand zero fill on playback, copy on capture
        setcfg(0, 2'd2, 2'd0, 1'b0, 2'd2);
        setcfg(1, 2'd2, 2'd0, 1'b1, 2'd1);
        for (int i = 0; i < 5; i++) begin
            put(0, 1'b0, 32'hA000 + i);
            put(1, 1'b0, 32'h0000_8000 + i);
        end
        drain();

        // R8: settings change with a pair half received
        setcfg(0, 2'd1, 2'd2, 1'b0, 2'd2);
        drain();
        put(0, 1'b0, 32'h100);
        while (inq[0].size() > 0) step();
        setcfg(0, 2'd2, 2'd0, 1'b1, 2'd2);
        repeat (4) step();
        chk(expq[0].size() == 0 && !ovld[0], "R8 no output mid pair", {32'd0, ovld[0]}, 33'd0);
        put(0, 1'b1, 32'h300);
        put(0, 1'b0, 32'h40);
        drain();

        for (int d = 0; d < 2; d++)
            chk(expq[d].size() == 0 && inq[d].size() == 0, "R9 all drained",
                expq[d].size(), 33'd0);
        finish_run();
    end
endmodule